// File: doc/BRIEF.md
# Vertical Sync Pulse and Retrace Status Flag

This block generates the active-high vertical sync pulse for a display timing chain and keeps a software-polled flag that records the start of each vertical retrace. It watches a scanline count supplied by an external line counter. When that count equals a full-width start line, sync turns on. Once sync is on, it turns off when the low bits of the count equal a short end field. Software programs that end field as the low bits of (start line + pulse width in scanlines).

The first cycle in which sync turns on marks the start of a retrace. If the active-low enable is 0, that event sets a sticky pending flag. Software clears the flag by holding the active-low clear input at 0. It must return the clear input to 1 before a later retrace can set the flag again. The flag is only a status bit: the block drives no interrupt line. The next stage may invert the sync output if the display needs the other polarity. All pins are plain control and status levels. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `vsync_retrace_irq`

## Requirements
- R1: After reset, `vsync` and `retrace_pending` are both 0.
- R2: While `vsync` is 0, if `line_cnt` equals `sync_start` on all LINE_W bits at a clock edge, `vsync` is 1 after that edge. Otherwise it stays 0.
- R3: While `vsync` is 1, if bits [END_W-1:0] of `line_cnt` equal `sync_end` at a clock edge, `vsync` is 0 after that edge. The upper bits of `line_cnt` play no part in this. Otherwise `vsync` stays 1.
- R4: While `vsync` is 0, a match between the low bits of `line_cnt` and `sync_end` has no effect on `vsync`.
- R5: At an edge where sync turns on (R2), `retrace_pending` is set if `irq_en_n` is 0 and `irq_clr_n` is 1. It is visible in the same cycle that `vsync` first reads 1.
- R6: When `irq_en_n` is 1, a retrace start does not set `retrace_pending`.
- R7: Any edge at which `irq_clr_n` is 0 leaves `retrace_pending` at 0. This holds even when a retrace start happens at that same edge, so clear has priority over set.
- R8: Once set, `retrace_pending` stays 1 through later retrace starts and through changes of `irq_en_n`, until a clear (R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_cnt | input | LINE_W | Current scanline count |
| sync_start | input | LINE_W | Scanline on which sync begins |
| sync_end | input | END_W | Low bits of (start + width) at which sync ends |
| irq_en_n | input | 1 | Active-low retrace flag enable |
| irq_clr_n | input | 1 | Active-low level clear of the retrace flag |
| vsync | output | 1 | Active-high vertical sync |
| retrace_pending | output | 1 | Polled retrace-started status flag |

## Verification
The bench builds the block with LINE_W = 10 and the default END_W = 4, and counts scanlines in a short frame of 40 lines. In that frame, a count that matches only in its low four bits, such as line 17 against an end field of 1, comes up a few cycles after sync starts. This lets the bench show that the end compare uses only the low bits. It also drives an end-field match while sync is off, to show that the match has no effect then. With the narrower counter, random start values hit the line count often, so the random phase reaches clear-versus-set collisions and repeated retrace starts.

// File: rtl/vsync_pkg.sv
package vsync_pkg;
  typedef enum logic {
    VS_IDLE   = 1'b0,
    VS_ACTIVE = 1'b1
  } vs_state_e;
endpackage

// File: rtl/vs_line_match.sv
module vs_line_match #(
  parameter int LINE_W = 11,
  parameter int END_W  = 4
) (
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [LINE_W-1:0] sync_start,
  input  logic [END_W-1:0]  sync_end,
  output logic              start_hit,
  output logic              end_hit
);
  localparam int CMP_W = (END_W < LINE_W) ? END_W : LINE_W;

  assign start_hit = (line_cnt == sync_start);

  generate
    if (END_W >= LINE_W) begin : g_full_end
      assign end_hit = (line_cnt == sync_end[LINE_W-1:0]);
    end else begin : g_part_end
      assign end_hit = (line_cnt[CMP_W-1:0] == sync_end[CMP_W-1:0]);
    end
  endgenerate
endmodule

// File: rtl/vs_sync_fsm.sv
module vs_sync_fsm
  import vsync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_hit,
  input  logic end_hit,
  output logic vsync,
  output logic retrace_start
);
  vs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      VS_IDLE:   if (start_hit) state_d = VS_ACTIVE;
      VS_ACTIVE: if (end_hit)   state_d = VS_IDLE;
      default:   state_d = VS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= VS_IDLE;
    else        state_q <= state_d;
  end

  assign vsync         = (state_q == VS_ACTIVE);
  assign retrace_start = (state_q == VS_IDLE) && start_hit;
endmodule

// File: rtl/vs_pend_latch.sv
module vs_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic retrace_start,
  input  logic irq_en_n,
  input  logic irq_clr_n,
  output logic pending
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        pend_q <= 1'b0;
    else if (!irq_clr_n)               pend_q <= 1'b0;
    else if (retrace_start && !irq_en_n) pend_q <= 1'b1;
  end

  assign pending = pend_q;
endmodule

// File: rtl/vsync_retrace_irq.sv
module vsync_retrace_irq #(
  parameter int LINE_W = 11,
  parameter int END_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [LINE_W-1:0] sync_start,
  input  logic [END_W-1:0]  sync_end,
  input  logic              irq_en_n,
  input  logic              irq_clr_n,
  output logic              vsync,
  output logic              retrace_pending
);
  logic start_hit, end_hit, retrace_start;

  vs_line_match #(.LINE_W(LINE_W), .END_W(END_W)) u_match (
    .line_cnt  (line_cnt),
    .sync_start(sync_start),
    .sync_end  (sync_end),
    .start_hit (start_hit),
    .end_hit   (end_hit)
  );

  vs_sync_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_hit    (start_hit),
    .end_hit      (end_hit),
    .vsync        (vsync),
    .retrace_start(retrace_start)
  );

  vs_pend_latch u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .retrace_start(retrace_start),
    .irq_en_n     (irq_en_n),
    .irq_clr_n    (irq_clr_n),
    .pending      (retrace_pending)
  );
endmodule

// File: rtl/vsync_retrace_irq_chk.sv
module vsync_retrace_irq_chk #(
  parameter int LINE_W = 11,
  parameter int END_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINE_W-1:0] line_cnt,
  input logic [LINE_W-1:0] sync_start,
  input logic [END_W-1:0]  sync_end,
  input logic              irq_en_n,
  input logic              irq_clr_n,
  input logic              vsync,
  input logic              retrace_pending
);
  localparam int CW = (END_W < LINE_W) ? END_W : LINE_W;
  logic s_hit, e_hit;
  assign s_hit = (line_cnt == sync_start);
  assign e_hit = (line_cnt[CW-1:0] == sync_end[CW-1:0]);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync && s_hit) |=> vsync);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync && !s_hit) |=> !vsync);
  p_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && e_hit) |=> !vsync);
  p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !e_hit) |=> vsync);
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync && s_hit && !irq_en_n && irq_clr_n) |=> retrace_pending);
  p_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrace_pending && irq_en_n) |=> !retrace_pending);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_clr_n |=> !retrace_pending);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (retrace_pending && irq_clr_n) |=> retrace_pending);
  p_only_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retrace_pending) |-> $rose(vsync));
endmodule

bind vsync_retrace_irq vsync_retrace_irq_chk #(.LINE_W(LINE_W), .END_W(END_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .line_cnt       (line_cnt),
  .sync_start     (sync_start),
  .sync_end       (sync_end),
  .irq_en_n       (irq_en_n),
  .irq_clr_n      (irq_clr_n),
  .vsync          (vsync),
  .retrace_pending(retrace_pending)
);

// File: tb/vsync_retrace_irq_tb.sv
module vsync_retrace_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 10;
  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] line_cnt = '0;
  logic [LW-1:0] sync_start = '0;
  logic [EW-1:0] sync_end = '0;
  logic          irq_en_n = 1'b1;
  logic          irq_clr_n = 1'b1;
  logic          vsync, retrace_pending;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsync_retrace_irq #(.LINE_W(LW), .END_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_cnt(line_cnt), .sync_start(sync_start),
    .sync_end(sync_end), .irq_en_n(irq_en_n), .irq_clr_n(irq_clr_n),
    .vsync(vsync), .retrace_pending(retrace_pending)
  );

  // behavioural reference
  bit m_vs = 0;
  bit m_pend = 0;
  always @(posedge clk) begin
    bit starting;
    if (!rst_n) begin
      m_vs = 0; m_pend = 0;
    end else begin
      starting = !m_vs && (int'(line_cnt) == int'(sync_start));
      if (!irq_clr_n) m_pend = 0;
      else if (starting && !irq_en_n) m_pend = 1;
      if (starting) m_vs = 1;
      else if (m_vs && ((int'(line_cnt) % 16) == int'(sync_end))) m_vs = 0;
    end
  end

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the reference every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(vsync, m_vs, "R2/R3 model vsync");
      chk(retrace_pending, m_pend, "R5/R7 model pending");
    end
  end

  task automatic step(input int ln);
    line_cnt = LW'(ln);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(vsync, 1'b0, "R1 vsync reset");
    chk(retrace_pending, 1'b0, "R1 pending reset");
    rst_n = 1'b1;
    sync_start = 10'd30;
    sync_end   = 4'd1;   // (30 + 3) mod 16
    irq_en_n = 1'b0;
    irq_clr_n = 1'b1;
    step(29); chk(vsync, 1'b0, "R2 before start");
    step(30); chk(vsync, 1'b1, "R2 start line");
    chk(retrace_pending, 1'b1, "R5 set with sync");
    step(31); chk(vsync, 1'b1, "R3 hold");
    step(17); chk(vsync, 1'b0, "R3 low-bit end only");
    step(1);  chk(vsync, 1'b0, "R4 end match while idle");
    chk(retrace_pending, 1'b1, "R8 sticky");
    irq_en_n = 1'b1;
    step(30); chk(retrace_pending, 1'b1, "R8 sticky on new start");
    irq_en_n = 1'b0;
    irq_clr_n = 1'b0;
    step(33); chk(vsync, 1'b0, "R3 end at 33");
    chk(retrace_pending, 1'b0, "R7 clear");
    step(30); chk(vsync, 1'b1, "R2 start with clear held");
    chk(retrace_pending, 1'b0, "R7 clear beats set");
    step(33);
    irq_clr_n = 1'b1;
    irq_en_n = 1'b1;
    step(30); chk(retrace_pending, 1'b0, "R6 disabled");
    step(33);
    irq_en_n = 1'b0;
    step(30); chk(retrace_pending, 1'b1, "R5 set after re-enable");
    step(33);
    // random phase, checked by the reference model
    for (int i = 0; i < 2000; i++) begin
      line_cnt = LW'($urandom_range(0, 40));
      if ((i % 50) == 0) sync_start = LW'($urandom_range(0, 40));
      if ((i % 37) == 0) sync_end = EW'($urandom_range(0, 15));
      irq_en_n  = ($urandom_range(0, 3) == 0);
      irq_clr_n = ($urandom_range(0, 7) != 0);
      @(negedge clk);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule